// File: doc/BRIEF.md
# Sequential Shift-Add Signed Multiplier

This block multiplies two signed two's-complement operands without any hardware multiplier. On an accepted start it takes the magnitude of the first operand X as a residual, clears the accumulator and remembers the sign of X. Each following clock cycle it finds the lowest set bit i of the residual. It adds the second operand Y shifted left by i places into the accumulator, or subtracts it when X was negative, and then removes that bit from the residual. The run ends on the cycle in which the residual becomes zero.

The block is a linear-mode rotation engine cut down to multiplication. The run length therefore follows the number of set bits in |X| and not the operand width. A caller that can pick which operand goes into X should put the one with fewer set bits there. The product is as wide as the two operands together, so every product, including the one made from two most-negative operands, fits without overflow.

Top module: `linmul_core`

## Requirements
- R1: While reset is asserted (rst_n low), and on the cycle after it is released, busy, done and z_out are all zero.
- R2: When done is high, z_out holds the exact signed product x_in·y_in of the operands sampled with the accepted start, as an XW+YW bit two's-complement value.
- R3: Operands equal to the most negative value (bit pattern 1 followed by zeros) give the exact product. For example (-2048)·(-2048) = 4194304 with the default widths.
- R4: done rises exactly p clock edges after the edge that accepts start, where p is the number of set bits in |X|. When X = 0, done is already high in the cycle right after the accepting edge, and z_out is 0.
- R5: done is a one-cycle pulse. busy is high from the accepting edge until the edge on which done rises, and busy and done are never high together.
- R6: While the block is idle and start is low, z_out holds its value.
- R7: A start pulse that arrives while busy is high has no effect. The run in progress ends at its original time with the product of its original operands.
- R8: In the cycle after an accepted start, z_out reads 0 whatever the previous result was.
- R9: Set bits of |X| are consumed from least significant upward, one per cycle. After k busy cycles, z_out equals sign(X)·Y·(sum of 2^i over the k lowest set bits i of |X|).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication; sampled only while idle |
| x_in | input | XW | Signed operand whose bits are walked |
| y_in | input | YW | Signed operand that is shifted and accumulated |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle pulse: z_out now holds the product |
| z_out | output | XW+YW | Signed product / running accumulator |

## Verification
The most-negative operands are the sharpest corner. A design that takes the magnitude in too few bits, or grows the product one bit too narrow, returns the wrong sign or a wrapped value for (-2048)·(-2048) and for (-2048)·2047. Latency is checked against the popcount of |X|, including X = 0 and X = -1. A design that always runs the full width, or never takes the early exit, finishes late. The running sum is compared after every busy cycle, which catches a scan in the wrong direction or a step that removes more than one bit. A start pulse injected mid-run catches a design that reloads its operands. Idle cycles after done catch an accumulator that drifts or is not cleared at the next start.

// File: rtl/linmul_pkg.sv
package linmul_pkg;

    localparam int unsigned LM_DEF_XW = 12;
    localparam int unsigned LM_DEF_YW = 12;

    // bits needed to index a bit position inside a w-bit word
    function automatic int unsigned lm_idx_w(input int unsigned w);
        return (w <= 1) ? 1 : $clog2(w);
    endfunction

endpackage

// File: rtl/linmul_lsb_pick.sv
module linmul_lsb_pick #(
    parameter int unsigned W  = 12,
    parameter int unsigned IW = 4
) (
    input  logic [W-1:0]  vec,
    output logic [W-1:0]  onehot,
    output logic [IW-1:0] idx
);

    // isolate lowest set bit: v & -v
    assign onehot = vec & (~vec + W'(1));

    // encode one-hot position, one OR-tree per index bit
    for (genvar b = 0; b < IW; b++) begin : g_enc
        logic [W-1:0] sel_mask;
        always_comb begin
            for (int i = 0; i < W; i++) begin
                sel_mask[i] = ((i / (1 << b)) % 2) == 1;
            end
        end
        assign idx[b] = |(onehot & sel_mask);
    end

endmodule

// File: rtl/linmul_term.sv
module linmul_term #(
    parameter int unsigned YW = 12,
    parameter int unsigned ZW = 24,
    parameter int unsigned IW = 4
) (
    input  logic [YW-1:0] y_bits,
    input  logic [IW-1:0] sh,
    input  logic          neg,
    output logic [ZW-1:0] term
);

    logic [ZW-1:0] y_ext;
    logic [ZW-1:0] shifted;

    assign y_ext   = {{(ZW-YW){y_bits[YW-1]}}, y_bits};
    assign shifted = y_ext << sh;
    assign term    = neg ? (ZW'(0) - shifted) : shifted;

endmodule

// File: rtl/linmul_core.sv
module linmul_core
    import linmul_pkg::*;
#(
    parameter int unsigned XW = LM_DEF_XW,
    parameter int unsigned YW = LM_DEF_YW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [XW-1:0]      x_in,
    input  logic [YW-1:0]      y_in,
    output logic               busy,
    output logic               done,
    output logic [XW+YW-1:0]   z_out
);

    localparam int unsigned ZW = XW + YW;
    localparam int unsigned IW = lm_idx_w(XW);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic          neg;
        logic [XW-1:0] mag;
        logic [YW-1:0] y;
        logic [ZW-1:0] z;
    } lm_state_t;

    lm_state_t st_d, st_q;

    logic [XW-1:0] x_mag;
    logic [XW-1:0] low_onehot;
    logic [IW-1:0] low_idx;
    logic [ZW-1:0] step_term;

    // magnitude fits XW unsigned bits even for the most negative value
    assign x_mag = x_in[XW-1] ? (~x_in + XW'(1)) : x_in;

    linmul_lsb_pick #(.W(XW), .IW(IW)) u_pick (
        .vec    (st_q.mag),
        .onehot (low_onehot),
        .idx    (low_idx)
    );

    linmul_term #(.YW(YW), .ZW(ZW), .IW(IW)) u_term (
        .y_bits (st_q.y),
        .sh     (low_idx),
        .neg    (st_q.neg),
        .term   (step_term)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.z   = '0;
                st_d.neg = x_in[XW-1];
                st_d.mag = x_mag;
                st_d.y   = y_in;
                if (x_mag == '0) begin
                    st_d.done = 1'b1;
                end else begin
                    st_d.busy = 1'b1;
                end
            end
        end else begin
            st_d.z   = st_q.z + step_term;
            st_d.mag = st_q.mag - low_onehot;
            if (st_d.mag == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy  = st_q.busy;
    assign done  = st_q.done;
    assign z_out = st_q.z;

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !start) |=> !st_q.done);

    p_busy_done_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && !start) |=> $stable(z_out));

    p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && start) |=> ($stable(st_q.y) && $stable(st_q.neg)));

    p_clear_on_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && start) |=> (z_out == '0));

    p_one_bit_per_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> ($countones(st_q.mag) + 1 == $countones($past(st_q.mag))));

endmodule

// File: tb/linmul_core_tb.sv
module linmul_core_tb;

    localparam int NV = 12;
    localparam logic [11:0] VX [NV] = '{12'd3, 12'hFF9, 12'd100, 12'd0, 12'd1, 12'hFFF,
                                        12'd2047, 12'h800, 12'h800, 12'h555, 12'h400, 12'hC18};
    localparam logic [11:0] VY [NV] = '{12'd5, 12'd9, 12'hFE7, 12'd1234, 12'hFFF, 12'hFFF,
                                        12'd2047, 12'h800, 12'd2047, 12'hFFD, 12'd7, 12'd333};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] x_in = '0;
    logic [11:0] y_in = '0;
    logic        busy;
    logic        done;
    logic [23:0] z_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    linmul_core u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .x_in  (x_in),
        .y_in  (y_in),
        .busy  (busy),
        .done  (done),
        .z_out (z_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [23:0] act, input logic [23:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int mag_of(input logic [11:0] v);
        int s;
        s = $signed(v);
        return (s < 0) ? -s : s;
    endfunction

    function automatic int popc(input logic [11:0] v);
        int m;
        int c;
        m = mag_of(v);
        c = 0;
        for (int i = 0; i < 13; i++) if (((m >> i) & 1) == 1) c++;
        return c;
    endfunction

    // signed product of the k lowest set bits of |x|
    function automatic logic [23:0] partial(input logic [11:0] x, input logic [11:0] y, input int k);
        int m;
        int yi;
        int acc;
        int taken;
        m = mag_of(x);
        yi = $signed(y);
        acc = 0;
        taken = 0;
        for (int i = 0; i < 13; i++) begin
            if (((m >> i) & 1) == 1 && taken < k) begin
                acc = acc + yi * (1 << i);
                taken++;
            end
        end
        if ($signed(x) < 0) acc = -acc;
        return acc[23:0];
    endfunction

    task automatic run_op(input logic [11:0] x, input logic [11:0] y, input bit inj);
        logic [23:0] exp;
        logic [23:0] held;
        int          p;
        int          cnt;
        string       tag;
        p   = popc(x);
        exp = partial(x, y, 13);
        tag = (x == 12'h800 || y == 12'h800) ? "R3" : "R2";
        @(negedge clk);
        start = 1'b1; x_in = x; y_in = y;
        @(negedge clk);
        start = 1'b0; x_in = ~x; y_in = ~y;
        cnt = 0;
        check(z_out == '0, "R8", "cleared after start", z_out, '0);
        check(busy == (p > 0), "R5", "busy after start", {23'd0, busy}, {23'd0, p > 0});
        check(done == (p == 0), "R4", "done after start", {23'd0, done}, {23'd0, p == 0});
        while (!done && cnt < 40) begin
            if (inj && cnt == 2) begin
                start = 1'b1; x_in = 12'h001; y_in = 12'h7FF;
            end
            @(negedge clk);
            start = 1'b0;
            cnt++;
            if (!done) begin
                check(z_out == partial(x, y, cnt), "R9", "running sum", z_out, partial(x, y, cnt));
                check(busy == 1'b1, "R5", "busy during run", {23'd0, busy}, 24'd1);
            end
        end
        check(cnt == p, inj ? "R7" : "R4", "latency", 24'(cnt), 24'(p));
        check(z_out == exp, inj ? "R7" : tag, "product", z_out, exp);
        check(busy == 1'b0, "R5", "busy at done", {23'd0, busy}, '0);
        held = z_out;
        @(negedge clk);
        check(done == 1'b0, "R5", "done pulse width", {23'd0, done}, '0);
        check(z_out == held, "R6", "idle hold", z_out, held);
        @(negedge clk);
        check(z_out == held, "R6", "idle hold 2", z_out, held);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        check({busy, done} == 2'b00 && z_out == '0, "R1", "in reset", z_out, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, done} == 2'b00 && z_out == '0, "R1", "after release", z_out, '0);

        // vector table: R2, R3, R4, R5, R6, R8, R9
        for (int v = 0; v < NV; v++) begin
            run_op(VX[v], VY[v], 1'b0);
        end

        // R7: start pulse during a run is ignored
        run_op(12'h555, 12'd100, 1'b1);

        // R8: nonzero result, then X=0 must read 0 after start (R4)
        run_op(12'd5, 12'd5, 1'b0);
        run_op(12'd0, 12'h7FF, 1'b0);

        // R1: reset in mid-run
        @(negedge clk);
        start = 1'b1; x_in = 12'h7FF; y_in = 12'd9;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check({busy, done} == 2'b00 && z_out == '0, "R1", "mid-run reset", z_out, '0);
        rst_n = 1'b1;
        run_op(12'h801, 12'h801, 1'b0);

        summary();
        $finish;
    end

endmodule